// File: doc/BRIEF.md
# Buck Regulator Startup and Fault Sequencer

This block is the digital controller that brings a synchronous buck regulator up in a fixed order and recovers it from faults. It watches three comparator flags: supply above the power-on threshold, shutdown pin above the disable threshold, and overcurrent trip. It also takes completion strobes from the threshold-capture block and the soft-start ramp block. From these it drives the gate-driver enable, the oscillator enable and the error-amplifier enable. It also issues one-cycle start strobes to the capture and ramp blocks.

All timing is counted in pulses of a slow timebase tick. Three parameters set the lengths: the power-up delay, the short gap before the amplifier wakes, and the length of one soft-start period.

The machine has seven states, reported on `state_o`:
- WAIT=0
- DELAY=1
- SAMPLE=2
- INIT=3
- SOFT=4
- RUN=5
- HICCUP=6

Its transitions are:
- **WAIT→DELAY** when supply and shutdown pin are both high.
- **DELAY→SAMPLE** after the delay expires.
- **SAMPLE→INIT** on capture done.
- **INIT→SOFT** after the gap expires.
- **SOFT→RUN** on ramp done.
- **SOFT/RUN→HICCUP** on overcurrent.
- **HICCUP→INIT** after two soft-start periods.
- **any→WAIT** on shutdown or supply loss.

Top module: `buck_start_seq`

## Requirements
- R1: After reset `state_o` is 0 (WAIT) and every enable and strobe output is low.
- R2: The machine leaves WAIT only in a cycle where both `pwr_ok` and `sd_high` are high. Holding `sd_high` low keeps it in WAIT for as long as it is held.
- R3: DELAY moves to SAMPLE on exactly the DLY_TICKS-th tick pulse after entry. Cycles without a tick make no progress.
- R4: `cap_start` is high for exactly the one cycle in which `state_o` first shows SAMPLE. SAMPLE holds until `cap_done`. `drv_en` is low throughout DELAY and SAMPLE.
- R5: In INIT only `osc_en` is high. After INIT_TICKS ticks the machine enters SOFT, and `ss_start` is high for that first SOFT cycle only.
- R6: In SOFT and RUN, `drv_en`, `osc_en` and `amp_en` are all high. `ss_done` in SOFT moves the machine to RUN.
- R7: `oc_trip` in SOFT or RUN moves the machine to HICCUP with all enables low. In SOFT, `oc_trip` wins over `ss_done`.
- R8: HICCUP lasts exactly 2*SS_TICKS ticks and then returns to INIT, skipping DELAY and SAMPLE.
- R9: `sd_high` low in any state sends the machine to WAIT at the next clock edge.
- R10: `pwr_ok` low sends the machine to WAIT at the next clock edge from any state, and takes priority over every other input.
- R11: `state_o` only ever shows codes 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| pwr_ok | input | 1 | Supply above the power-on threshold |
| sd_high | input | 1 | Shutdown pin above the disable threshold |
| oc_trip | input | 1 | Overcurrent comparator flag |
| cap_done | input | 1 | Threshold capture finished |
| ss_done | input | 1 | Soft-start ramp finished |
| drv_en | output | 1 | Gate-driver enable |
| osc_en | output | 1 | Oscillator enable |
| amp_en | output | 1 | Error-amplifier enable |
| cap_start | output | 1 | One-cycle start strobe for threshold capture |
| ss_start | output | 1 | One-cycle start strobe for the soft-start ramp |
| state_o | output | 3 | Current state code |

## Verification
The checker tests the following on every cycle:
- the priority exits to WAIT on supply loss or shutdown;
- the overcurrent exit from SOFT and RUN;
- the single-cycle width of both strobes and the state each strobe belongs to;
- the rule that the drivers switch on only after INIT;
- that the delay is frozen without a tick;
- the legal range of state codes.

The exact tick counts of the power-up delay and of the two-period hiccup wait can only be shown by the bench scenarios. The same holds for the return from HICCUP to INIT rather than to capture, and for a long shutdown hold during power-up.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_INIT   = 3'd3,
        ST_SOFT   = 3'd4,
        ST_RUN    = 3'd5,
        ST_HICCUP = 3'd6
    } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + W'(1);
    end

    // fires on the tick that completes the window
    assign done = tick && (cnt == limit - W'(1));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       sd_high,
    input  logic       oc_trip,
    input  logic       cap_done,
    input  logic       ss_done,
    input  logic       tmr_done,
    output seq_state_t state,
    output seq_state_t nxt,
    output logic       tmr_clr
);
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!pwr_ok || !sd_high) begin
            nxt = ST_WAIT;
        end else begin
            unique case (state)
                ST_WAIT:   nxt = ST_DELAY;
                ST_DELAY:  if (tmr_done) nxt = ST_SAMPLE;
                ST_SAMPLE: if (cap_done) nxt = ST_INIT;
                ST_INIT:   if (tmr_done) nxt = ST_SOFT;
                ST_SOFT: begin
                    if (oc_trip)      nxt = ST_HICCUP;
                    else if (ss_done) nxt = ST_RUN;
                end
                ST_RUN:    if (oc_trip)  nxt = ST_HICCUP;
                ST_HICCUP: if (tmr_done) nxt = ST_INIT;
                default:   nxt = ST_WAIT;
            endcase
        end
    end

    assign tmr_clr = (nxt != state);
endmodule

// File: rtl/seq_outdec.sv
module seq_outdec
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  seq_state_t nxt,
    output logic       drv_en,
    output logic       osc_en,
    output logic       amp_en,
    output logic       cap_start,
    output logic       ss_start
);
    always_comb begin
        drv_en = 1'b0;
        osc_en = 1'b0;
        amp_en = 1'b0;
        unique case (state)
            ST_INIT: osc_en = 1'b1;
            ST_SOFT, ST_RUN: begin
                drv_en = 1'b1;
                osc_en = 1'b1;
                amp_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_start <= 1'b0;
            ss_start  <= 1'b0;
        end else begin
            cap_start <= (nxt == ST_SAMPLE) && (state != ST_SAMPLE);
            ss_start  <= (nxt == ST_SOFT)   && (state != ST_SOFT);
        end
    end
endmodule

// File: rtl/buck_start_seq.sv
module buck_start_seq
    import bss_pkg::*;
#(
    parameter int DLY_TICKS  = 680,
    parameter int INIT_TICKS = 8,
    parameter int SS_TICKS   = 680
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pwr_ok,
    input  logic       sd_high,
    input  logic       oc_trip,
    input  logic       cap_done,
    input  logic       ss_done,
    output logic       drv_en,
    output logic       osc_en,
    output logic       amp_en,
    output logic       cap_start,
    output logic       ss_start,
    output logic [2:0] state_o
);
    localparam int HIC_TICKS = 2 * SS_TICKS;
    localparam int MAX_A     = (DLY_TICKS > INIT_TICKS) ? DLY_TICKS : INIT_TICKS;
    localparam int MAX_T     = (MAX_A > HIC_TICKS) ? MAX_A : HIC_TICKS;
    localparam int CW        = $clog2(MAX_T + 1);

    seq_state_t    state, nxt;
    logic          tmr_clr, tmr_done;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (state)
            ST_INIT:   limit = CW'(INIT_TICKS);
            ST_HICCUP: limit = CW'(HIC_TICKS);
            default:   limit = CW'(DLY_TICKS);
        endcase
    end

    seq_timer #(.W(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
        .limit(limit), .done(tmr_done)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .sd_high(sd_high),
        .oc_trip(oc_trip), .cap_done(cap_done), .ss_done(ss_done),
        .tmr_done(tmr_done), .state(state), .nxt(nxt), .tmr_clr(tmr_clr)
    );

    seq_outdec u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .nxt(nxt),
        .drv_en(drv_en), .osc_en(osc_en), .amp_en(amp_en),
        .cap_start(cap_start), .ss_start(ss_start)
    );

    assign state_o = state;
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       pwr_ok,
    input logic       sd_high,
    input logic       oc_trip,
    input logic       drv_en,
    input logic       amp_en,
    input logic       osc_en,
    input logic       cap_start,
    input logic       ss_start,
    input logic [2:0] state_o
);
    // R10
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> state_o == 3'd0);

    // R9
    sd_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !sd_high) |=> state_o == 3'd0);

    // R7
    oc_hiccup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && sd_high && oc_trip && (state_o == 3'd4 || state_o == 3'd5))
        |=> (state_o == 3'd6 && !drv_en && !osc_en && !amp_en));

    // R4
    cap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start |-> (state_o == 3'd2) ##1 !cap_start);

    // R5
    ss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_start |-> (state_o == 3'd4) ##1 !ss_start);

    // R6
    drv_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> ($past(state_o) == 3'd3 && amp_en));

    // R3
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !tick && pwr_ok && sd_high) |=> state_o == 3'd1);

    // R11
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd6);
endmodule

bind buck_start_seq bss_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
    .sd_high(sd_high), .oc_trip(oc_trip), .drv_en(drv_en),
    .amp_en(amp_en), .osc_en(osc_en), .cap_start(cap_start),
    .ss_start(ss_start), .state_o(state_o)
);

// File: tb/sim_buck_start_seq.sv
module sim_buck_start_seq;
    localparam int DLY  = 2;
    localparam int INIT = 1;
    localparam int SS   = 2;
    localparam int NV   = 17;

    // {pwr, sd, oc, cap_done, ss_done, tick, state[2:0], drv, osc, amp, cap_start, ss_start}
    localparam logic [13:0] VEC [NV] = '{
        14'b1_0_0_0_0_1_000_00000,
        14'b1_1_0_0_0_0_001_00000,
        14'b1_1_0_0_0_1_001_00000,
        14'b1_1_0_0_0_1_010_00010,
        14'b1_1_0_0_0_0_010_00000,
        14'b1_1_0_1_0_0_011_01000,
        14'b1_1_0_0_0_1_100_11101,
        14'b1_1_0_0_0_0_100_11100,
        14'b1_1_0_0_1_0_101_11100,
        14'b1_1_1_0_0_0_110_00000,
        14'b1_1_0_0_0_1_110_00000,
        14'b1_1_0_0_0_1_110_00000,
        14'b1_1_0_0_0_1_110_00000,
        14'b1_1_0_0_0_1_011_01000,
        14'b1_1_0_0_0_1_100_11101,
        14'b1_0_0_0_0_0_000_00000,
        14'b1_1_0_0_0_0_001_00000
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, pwr_ok = 0, sd_high = 0, oc_trip = 0, cap_done = 0, ss_done = 0;
    logic drv_en, osc_en, amp_en, cap_start, ss_start;
    logic [2:0] state_o;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    buck_start_seq #(.DLY_TICKS(DLY), .INIT_TICKS(INIT), .SS_TICKS(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok), .sd_high(sd_high),
        .oc_trip(oc_trip), .cap_done(cap_done), .ss_done(ss_done),
        .drv_en(drv_en), .osc_en(osc_en), .amp_en(amp_en),
        .cap_start(cap_start), .ss_start(ss_start), .state_o(state_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_in(logic p, logic s, logic o, logic c, logic d, logic t);
        pwr_ok = p; sd_high = s; oc_trip = o; cap_done = c; ss_done = d; tick = t;
    endtask

    function automatic int outs();
        return {27'd0, drv_en, osc_en, amp_en, cap_start, ss_start};
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        // R1 reset state
        set_in(1, 1, 0, 0, 0, 1);
        step(); step();
        check("R1 state", state_o, 0);
        check("R1 outs", outs(), 0);
        set_in(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step();

        // table walk: full power-up, hiccup, shutdown re-arm (R2..R9)
        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8]);
            step();
            check($sformatf("R2-seq row %0d state", i), state_o, int'(VEC[i][7:5]));
            check($sformatf("R6 R4 R5 row %0d outs", i), outs(), int'(VEC[i][4:0]));
        end

        // R3: no tick holds DELAY, then exactly DLY ticks
        set_in(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step();
        check("R3 frozen without tick", state_o, 1);
        tick = 1;
        n = 0;
        for (int i = 0; i < 20 && state_o == 3'd1; i++) begin step(); n++; end
        check("R3 delay ticks", n, DLY);
        check("R4 state after delay", state_o, 2);
        check("R4 drv low in sample", drv_en, 0);
        tick = 0; cap_done = 1; step(); cap_done = 0;
        tick = 1; step(); tick = 0;
        check("R5 in soft", state_o, 4);
        ss_done = 1; step(); ss_done = 0;
        check("R6 in run", state_o, 5);

        // R10 supply loss from RUN
        set_in(0, 1, 0, 0, 0, 0);
        step();
        check("R10 pwr loss state", state_o, 0);
        check("R10 pwr loss outs", outs(), 0);

        // R2 shutdown held low during power-up
        set_in(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 10; i++) step();
        check("R2 held in wait", state_o, 0);
        sd_high = 1; tick = 0; step();
        check("R2 release", state_o, 1);
        tick = 1; step(); step(); tick = 0;
        cap_done = 1; step(); cap_done = 0;
        tick = 1; step(); tick = 0;
        check("R5 soft again", state_o, 4);

        // R7 oc wins over ss_done in SOFT; R8 hiccup length
        oc_trip = 1; ss_done = 1; step(); oc_trip = 0; ss_done = 0;
        check("R7 hiccup entry", state_o, 6);
        check("R7 outs off", outs(), 0);
        tick = 1;
        n = 0;
        for (int i = 0; i < 20 && state_o == 3'd6; i++) begin step(); n++; end
        tick = 0;
        check("R8 hiccup ticks", n, 2 * SS);
        check("R8 returns to init", state_o, 3);

        // R9 shutdown from INIT
        sd_high = 0; step();
        check("R9 rearm from init", state_o, 0);
        check("R11 code range", int'(state_o <= 3'd6), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule